// File: doc/BRIEF.md
# USB Host Root-Port Control and Status Register

This block holds the single 32-bit control and status word for one USB host root port. Software reaches it over a simple register bus: a write strobe with write data, and a read-data word that always shows the current contents. The port logic reports events through inputs to the block: device presence, the end of a bus-reset sequence, the overcurrent level, remote wakeup, the negotiated speed and the two data-line levels. The block drives the port's power, reset, suspend, resume and test-pattern controls. It also raises a port interrupt.

The design is organised around two state machines. The link machine tracks attachment and enable with three states: `LS_DETACHED`, `LS_ATTACHED` and `LS_ENABLED`. Its transitions are T_CONNECT (detached to attached when presence rises), T_DETACH (any state to detached when presence falls), T_ENABLE (attached to enabled when a reset sequence completes with no overcurrent) and T_DISABLE (enabled to attached on overcurrent or a software disable). The power-state machine holds `PS_ACTIVE`, `PS_SUSPENDED` and `PS_RESUMING`. Its transitions are T_SUSPEND (a software write of suspend alone), T_RESUME (a software write of resume, or a remote wakeup), T_WAKE_IDLE (a software write clearing both) and T_DROP (a disconnect forces `PS_ACTIVE`). The change flags are sticky: hardware sets them, and software clears them by writing 1.

Top module: `usb_hport_reg`

## Requirements
- R1: After reset every register bit reads 0, every control output is 0 and the interrupt is low.
- R2: Bit 0 reads the presence input as registered one cycle earlier. Bit 1 sets in the cycle after presence rises and stays set until software writes 1 to bit 1.
- R3: Bit 2 (enable) becomes 1 only when a reset-done pulse arrives while a device is attached and there is no overcurrent. It clears on disconnect, while overcurrent is high, or when software writes 1 to bit 2. Writing 0 to bit 2 has no effect.
- R4: Bit 3 sets in every cycle in which bit 2 changes value. Writing 1 to bit 3 clears it.
- R5: Bit 4 reads the overcurrent input as registered one cycle earlier. Bit 5 sets whenever that value changes. Writing 1 to bit 5 clears it.
- R6: When a hardware set and a software write-1 clear reach bit 1, 3 or 5 in the same cycle, the bit ends up set.
- R7: Bit 12 (power) takes the written value. It is forced to 0 in any cycle in which the overcurrent input is high, even if a write sets it in that cycle.
- R8: Bit 7 (suspend) is written by software. A write that also sets bit 6 or bit 8 leaves it 0. It is cleared by a remote wakeup or a disconnect.
- R9: Bit 6 (resume) takes the written value. A remote wakeup sets it, and a disconnect clears it; the disconnect wins over the wakeup.
- R10: Bit 8 (port reset) takes the written value. A reset-done pulse clears it when no write happens in that cycle, whether or not a device is attached.
- R11: Bits 16:13 store any written test code. The test-mode output equals the code for 0 to 5 (0 off, 1 J, 2 K, 3 SE0_NAK, 4 packet, 5 force-enable) and is 0 for codes 6 to 15.
- R12: Bits 18:17 read the registered speed input (0 high, 1 full, 2 low). Bit 10 reads D+ and bit 11 reads D-. Bit 9 and bits 31:19 read 0.
- R13: The interrupt output is high exactly when bit 1, 3 or 5 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register contents |
| dev_present | input | 1 | Device attached level from the port logic |
| rst_done | input | 1 | One-cycle pulse at the end of a bus-reset sequence |
| ovc_in | input | 1 | Overcurrent level |
| wakeup_det | input | 1 | One-cycle remote-wakeup pulse |
| speed_in | input | 2 | Negotiated speed code |
| line_dp | input | 1 | D+ line level |
| line_dm | input | 1 | D- line level |
| port_power | output | 1 | Port power control |
| port_reset | output | 1 | Drives bus reset while high |
| port_suspend | output | 1 | Port suspended |
| port_resume | output | 1 | Drives resume signalling while high |
| test_mode | output | 4 | Active test pattern, 0 when none |
| port_irq | output | 1 | Port interrupt |

## Verification
The hardest case to bring about is a hardware set landing on a sticky flag in the same cycle as a software write-1 clear of that flag. The enable-change case is the hardest of these, because it needs the link machine already in `LS_ENABLED`. The stimulus first attaches a device and completes a reset. It then raises overcurrent in the same cycle as a write that clears bits 3 and 5, so both change flags see a set and a clear together. Directed phases also cover a disconnect arriving during resume and a wakeup during suspend. A long weighted-random phase then checks every clock against a behavioural model.

// File: rtl/usb_hport_pkg.sv
package usb_hport_pkg;
    localparam int DATA_W   = 32;
    localparam int TEST_W   = 4;
    localparam int SPD_W    = 2;
    localparam int TEST_MAX = 5;

    localparam int B_CONN   = 0;
    localparam int B_CDET   = 1;
    localparam int B_EN     = 2;
    localparam int B_ENCHG  = 3;
    localparam int B_OVC    = 4;
    localparam int B_OVCCHG = 5;
    localparam int B_RES    = 6;
    localparam int B_SUSP   = 7;
    localparam int B_RST    = 8;
    localparam int B_DP     = 10;
    localparam int B_DM     = 11;
    localparam int B_PWR    = 12;
    localparam int B_TST    = 13;
    localparam int B_SPD    = 17;
    localparam int B_TOP    = B_SPD + SPD_W;

    localparam int N_STICKY = 3;

    typedef enum logic [1:0] {
        LS_DETACHED = 2'd0,
        LS_ATTACHED = 2'd1,
        LS_ENABLED  = 2'd2
    } link_state_e;

    typedef enum logic [1:0] {
        PS_ACTIVE    = 2'd0,
        PS_SUSPENDED = 2'd1,
        PS_RESUMING  = 2'd2
    } pwr_state_e;
endpackage

// File: rtl/usb_hport_link.sv
module usb_hport_link
    import usb_hport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dev_present,
    input  logic rst_done,
    input  logic ovc_in,
    input  logic sw_disable,
    output logic conn_sts,
    output logic conn_ev,
    output logic disc_ev,
    output logic enabled,
    output logic en_toggle
);
    link_state_e state_q, state_d;
    logic        present_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= LS_DETACHED;
            present_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            present_q <= dev_present;
        end
    end

    assign conn_ev = dev_present & ~present_q;
    assign disc_ev = ~dev_present & present_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_DETACHED: begin
                if (conn_ev) state_d = LS_ATTACHED;          // T_CONNECT
            end
            LS_ATTACHED: begin
                if (disc_ev) state_d = LS_DETACHED;          // T_DETACH
                else if (rst_done && !ovc_in) state_d = LS_ENABLED; // T_ENABLE
            end
            LS_ENABLED: begin
                if (disc_ev) state_d = LS_DETACHED;          // T_DETACH
                else if (ovc_in || sw_disable) state_d = LS_ATTACHED; // T_DISABLE
            end
            default: state_d = LS_DETACHED;
        endcase
    end

    always_comb begin
        conn_sts  = present_q;
        enabled   = (state_q == LS_ENABLED);
        en_toggle = (state_q == LS_ENABLED) != (state_d == LS_ENABLED);
    end
endmodule

// File: rtl/usb_hport_sticky.sv
module usb_hport_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q[i] <= 1'b0;
            else if (set_i[i]) q[i] <= 1'b1;
            else if (clr_i[i]) q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/usb_hport_ctl.sv
module usb_hport_ctl
    import usb_hport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              wr_pwr,
    input  logic              wr_rst,
    input  logic              wr_susp,
    input  logic              wr_res,
    input  logic [TEST_W-1:0] wr_test,
    input  logic              ovc_in,
    input  logic              rst_done,
    input  logic              wakeup_det,
    input  logic              disc_ev,
    output logic              power,
    output logic              reset,
    output logic              suspend,
    output logic              resume,
    output logic [TEST_W-1:0] test_code,
    output logic [TEST_W-1:0] test_out
);
    pwr_state_e ps_q, ps_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= PS_ACTIVE;
        else        ps_q <= ps_d;
    end

    always_comb begin
        ps_d = ps_q;
        unique case (ps_q)
            PS_ACTIVE, PS_SUSPENDED, PS_RESUMING: begin
                if (wr) begin
                    if (wr_res)                ps_d = PS_RESUMING;  // T_RESUME
                    else if (wr_susp && !wr_rst) ps_d = PS_SUSPENDED; // T_SUSPEND
                    else                       ps_d = PS_ACTIVE;    // T_WAKE_IDLE
                end
                if (wakeup_det) ps_d = PS_RESUMING;                 // T_RESUME
                if (disc_ev)    ps_d = PS_ACTIVE;                   // T_DROP
            end
            default: ps_d = PS_ACTIVE;
        endcase
    end

    always_comb begin
        suspend = (ps_q == PS_SUSPENDED);
        resume  = (ps_q == PS_RESUMING);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            power     <= 1'b0;
            reset     <= 1'b0;
            test_code <= '0;
        end else begin
            if (ovc_in)  power <= 1'b0;
            else if (wr) power <= wr_pwr;
            if (wr)            reset <= wr_rst;
            else if (rst_done) reset <= 1'b0;
            if (wr) test_code <= wr_test;
        end
    end

    assign test_out = (int'(test_code) <= TEST_MAX) ? test_code : '0;
endmodule

// File: rtl/usb_hport_reg.sv
module usb_hport_reg
    import usb_hport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dev_present,
    input  logic              rst_done,
    input  logic              ovc_in,
    input  logic              wakeup_det,
    input  logic [SPD_W-1:0]  speed_in,
    input  logic              line_dp,
    input  logic              line_dm,
    output logic              port_power,
    output logic              port_reset,
    output logic              port_suspend,
    output logic              port_resume,
    output logic [TEST_W-1:0] test_mode,
    output logic              port_irq
);
    logic [DATA_W-1:0]   w1;
    logic                conn_sts, conn_ev, disc_ev, enabled, en_toggle;
    logic                ovc_q;
    logic [SPD_W-1:0]    spd_q;
    logic                dp_q, dm_q;
    logic [N_STICKY-1:0] stk_set, stk_clr, stk_q;
    logic [TEST_W-1:0]   test_code;
    logic                unused_wbits;

    assign w1 = reg_wr ? reg_wdata : '0;
    assign unused_wbits = ^{reg_wdata[DATA_W-1:B_TST+TEST_W], reg_wdata[B_DM:B_DP+0],
                            reg_wdata[9], reg_wdata[B_OVC], reg_wdata[B_CONN]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovc_q <= 1'b0;
            spd_q <= '0;
            dp_q  <= 1'b0;
            dm_q  <= 1'b0;
        end else begin
            ovc_q <= ovc_in;
            spd_q <= speed_in;
            dp_q  <= line_dp;
            dm_q  <= line_dm;
        end
    end

    usb_hport_link u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_present(dev_present),
        .rst_done   (rst_done),
        .ovc_in     (ovc_in),
        .sw_disable (w1[B_EN]),
        .conn_sts   (conn_sts),
        .conn_ev    (conn_ev),
        .disc_ev    (disc_ev),
        .enabled    (enabled),
        .en_toggle  (en_toggle)
    );

    assign stk_set = {ovc_in != ovc_q, en_toggle, conn_ev};
    assign stk_clr = {w1[B_OVCCHG], w1[B_ENCHG], w1[B_CDET]};

    usb_hport_sticky #(.N(N_STICKY)) u_sticky (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(stk_set),
        .clr_i(stk_clr),
        .q    (stk_q)
    );

    usb_hport_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .wr_pwr    (reg_wdata[B_PWR]),
        .wr_rst    (reg_wdata[B_RST]),
        .wr_susp   (reg_wdata[B_SUSP]),
        .wr_res    (reg_wdata[B_RES]),
        .wr_test   (reg_wdata[B_TST +: TEST_W]),
        .ovc_in    (ovc_in),
        .rst_done  (rst_done),
        .wakeup_det(wakeup_det),
        .disc_ev   (disc_ev),
        .power     (port_power),
        .reset     (port_reset),
        .suspend   (port_suspend),
        .resume    (port_resume),
        .test_code (test_code),
        .test_out  (test_mode)
    );

    always_comb begin
        reg_rdata                  = '0;
        reg_rdata[B_CONN]          = conn_sts;
        reg_rdata[B_CDET]          = stk_q[0];
        reg_rdata[B_EN]            = enabled;
        reg_rdata[B_ENCHG]         = stk_q[1];
        reg_rdata[B_OVC]           = ovc_q;
        reg_rdata[B_OVCCHG]        = stk_q[2];
        reg_rdata[B_RES]           = port_resume;
        reg_rdata[B_SUSP]          = port_suspend;
        reg_rdata[B_RST]           = port_reset;
        reg_rdata[B_DP]            = dp_q;
        reg_rdata[B_DM]            = dm_q;
        reg_rdata[B_PWR]           = port_power;
        reg_rdata[B_TST +: TEST_W] = test_code;
        reg_rdata[B_SPD +: SPD_W]  = spd_q;
    end

    assign port_irq = |stk_q;
endmodule

// File: rtl/usb_hport_chk.sv
module usb_hport_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] reg_rdata,
    input logic        dev_present,
    input logic        rst_done,
    input logic        ovc_in,
    input logic        wakeup_det,
    input logic        port_power,
    input logic        port_suspend,
    input logic [3:0]  test_mode,
    input logic        port_irq
);
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r2_conn_follows: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> reg_rdata[0] == $past(dev_present));

    a_r3_enable_from_done: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && reg_rdata[2] && !$past(reg_rdata[2])) |-> $past(rst_done));

    a_r4_enchg_on_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && reg_rdata[2] != $past(reg_rdata[2])) |-> reg_rdata[3]);

    a_r7_ovc_kills_power: assert property (@(posedge clk) disable iff (!rst_n)
        ovc_in |=> !port_power);

    a_r8_wake_ends_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        wakeup_det |=> !port_suspend);

    a_r11_test_legal: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode <= 4'd5);

    a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31:19] == 13'd0 && !reg_rdata[9]);

    a_r13_irq_or: assert property (@(posedge clk) disable iff (!rst_n)
        port_irq == (reg_rdata[1] | reg_rdata[3] | reg_rdata[5]));
endmodule

bind usb_hport_reg usb_hport_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_rdata   (reg_rdata),
    .dev_present (dev_present),
    .rst_done    (rst_done),
    .ovc_in      (ovc_in),
    .wakeup_det  (wakeup_det),
    .port_power  (port_power),
    .port_suspend(port_suspend),
    .test_mode   (test_mode),
    .port_irq    (port_irq)
);

// File: tb/usb_hport_reg_bench.sv
`timescale 1ns/1ps
module usb_hport_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dev_present = 1'b0, rst_done = 1'b0, ovc_in = 1'b0, wakeup_det = 1'b0;
    logic [1:0]  speed_in = '0;
    logic        line_dp = 1'b0, line_dm = 1'b0;
    logic        port_power, port_reset, port_suspend, port_resume, port_irq;
    logic [3:0]  test_mode;

    always #2.5 clk = ~clk;

    usb_hport_reg u_usb_hport_reg (.*);

    int vectors = 0, fails = 0;
    bit done = 0;

    // behavioural reference state
    bit m_conn, m_cdet, m_en, m_enchg, m_ovc, m_ovcchg, m_res, m_susp, m_rst, m_pwr, m_dp, m_dm;
    int m_link;          // 0 none, 1 attached, 2 enabled
    int m_test, m_spd;

    task automatic model_reset();
        m_conn = 0; m_cdet = 0; m_en = 0; m_enchg = 0; m_ovc = 0; m_ovcchg = 0;
        m_res = 0; m_susp = 0; m_rst = 0; m_pwr = 0; m_dp = 0; m_dm = 0;
        m_link = 0; m_test = 0; m_spd = 0;
    endtask

    task automatic model_next();
        bit [31:0] w = reg_wr ? reg_wdata : 32'd0;
        bit arrive = dev_present && !m_conn;
        bit leave  = !dev_present && m_conn;
        bit old_en = (m_link == 2);
        if (leave) m_link = 0;
        else if (arrive) m_link = 1;
        else if (m_link == 2 && (ovc_in || w[2])) m_link = 1;
        else if (m_link == 1 && rst_done && !ovc_in) m_link = 2;
        m_en = (m_link == 2);
        m_cdet   = arrive || (m_cdet && !w[1]);
        m_enchg  = (m_en != old_en) || (m_enchg && !w[3]);
        m_ovcchg = (ovc_in != m_ovc) || (m_ovcchg && !w[5]);
        m_ovc = ovc_in;
        if (ovc_in) m_pwr = 0; else if (reg_wr) m_pwr = reg_wdata[12];
        if (reg_wr) m_rst = reg_wdata[8]; else if (rst_done) m_rst = 0;
        if (reg_wr) begin
            m_susp = reg_wdata[7] && !reg_wdata[6] && !reg_wdata[8];
            m_res  = reg_wdata[6];
        end
        if (wakeup_det) begin m_res = 1; m_susp = 0; end
        if (leave)      begin m_res = 0; m_susp = 0; end
        if (reg_wr) m_test = int'(reg_wdata[16:13]);
        m_spd = int'(speed_in); m_dp = line_dp; m_dm = line_dm;
        m_conn = dev_present;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
        end
    endtask

    task automatic compare();
        vectors++;
        chk("R2", "conn_sts", reg_rdata[0], m_conn);
        chk("R2 R6", "conn_det", reg_rdata[1], m_cdet);
        chk("R3", "enable", reg_rdata[2], m_en);
        chk("R4 R6", "en_chg", reg_rdata[3], m_enchg);
        chk("R5", "ovc_act", reg_rdata[4], m_ovc);
        chk("R5 R6", "ovc_chg", reg_rdata[5], m_ovcchg);
        chk("R9", "resume", reg_rdata[6], m_res);
        chk("R9", "resume_out", port_resume, m_res);
        chk("R8", "suspend", reg_rdata[7], m_susp);
        chk("R8", "suspend_out", port_suspend, m_susp);
        chk("R10", "reset", reg_rdata[8], m_rst);
        chk("R10", "reset_out", port_reset, m_rst);
        chk("R12", "reserved9", reg_rdata[9], 0);
        chk("R12", "line_dp", reg_rdata[10], m_dp);
        chk("R12", "line_dm", reg_rdata[11], m_dm);
        chk("R7", "power", reg_rdata[12], m_pwr);
        chk("R7", "power_out", port_power, m_pwr);
        chk("R11", "test_field", int'(reg_rdata[16:13]), m_test);
        chk("R11", "test_out", int'(test_mode), (m_test <= 5) ? m_test : 0);
        chk("R12", "speed", int'(reg_rdata[18:17]), m_spd);
        chk("R12", "reserved_hi", int'(reg_rdata[31:19]), 0);
        chk("R13", "irq", port_irq, m_cdet | m_enchg | m_ovcchg);
    endtask

    task automatic step();
        model_next();
        @(posedge clk);
        @(negedge clk);
        compare();
        reg_wr = 0; rst_done = 0; wakeup_det = 0;
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr = 1; reg_wdata = d; step();
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare();                              // R1 reset state
        chk("R1", "rdata_reset", int'(reg_rdata), 0);
        chk("R1", "irq_reset", port_irq, 0);
        // R12 status read-back
        speed_in = 2'd2; line_dp = 1; step(); step();
        speed_in = 2'd1; line_dp = 0; line_dm = 1; step();
        // R2 connect and W1C
        dev_present = 1; step(); step();
        wr(32'h2);
        // R3 enable by reset done, R10 reset bit
        wr(32'h100); rst_done = 1; step();
        wr(32'h0);                              // R3 writing 0 keeps enable
        wr(32'h8);                              // R4 clear
        // R7 power, R11 test codes
        wr(32'h1000); wr(32'h1000 | (3 << 13)); wr(32'h1000 | (9 << 13)); wr(32'h1000 | (5 << 13));
        // R6 set and clear collide: overcurrent raised during W1C of bits 3 and 5, also power write
        ovc_in = 1; wr(32'h1028);
        step(); ovc_in = 0; step(); wr(32'h28);
        // R3 software disable after re-enable
        rst_done = 1; step(); wr(32'h4); wr(32'h8);
        // R8 suspend then wakeup; R9 resume
        wr(32'h80); wakeup_det = 1; step(); wr(32'h0);
        wr(32'h80); wr(32'h180); rst_done = 1; step();
        wr(32'h80); wr(32'hC0);
        // R9 disconnect while resuming, with wakeup colliding
        dev_present = 0; wakeup_det = 1; step();
        // R6 connect event with simultaneous clear of bit 1
        dev_present = 1; reg_wr = 1; reg_wdata = 32'h2; step(); step();
        // weighted random phase
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(15) == 0) dev_present = ~dev_present;
            if ($urandom_range(31) == 0) ovc_in = ~ovc_in;
            rst_done   = ($urandom_range(7) == 0);
            wakeup_det = ($urandom_range(31) == 0);
            speed_in   = 2'($urandom_range(2));
            line_dp    = 1'($urandom_range(1));
            line_dm    = 1'($urandom_range(1));
            reg_wr     = ($urandom_range(3) == 0);
            reg_wdata  = $urandom();
            step();
        end
        done = 1;
        summary();
    end
endmodule